// File: doc/BRIEF.md
# Pseudo-Random Sequence Error Checker with Lock Hold

This block sits on the receive side of a bit-error-rate measurement path. It watches a serial stream that should carry a maximal-length pseudo-random sequence and reports how many received bits disagree with that sequence. The reference sequence comes from a linear feedback shift register. Its default recurrence is x^15 + x^14 + 1. The register width and the two tap positions are parameters.

The checker has two modes. While hunting, it acts as a self-synchronizing descrambler. Every received bit is shifted into the register, so the register state follows the incoming stream. The checker compares each received bit with the value the register predicts and counts a run of agreements. Once that run is long enough, the checker declares lock and cuts the register off from the input. From then on the register generates the sequence on its own. A single corrupted line bit therefore gives exactly one counted error and is not spread across the taps.

While locked, the checker counts errors in fixed windows of received bits. If one window collects too many errors, the checker decides the pattern has slipped and goes back to hunting. A saturating error counter counts only while locked. Software clears it with a clear input.

Top module: `prbs_lock_checker`

## Requirements
- R1: After reset, `locked` is 0 and `err_count` is 0, and the register state is all zeros.
- R2: While unlocked, each valid bit is shifted into the register. The prediction for received bit n is bit n-15 XOR bit n-14 of the received stream, counting only valid bits. Register positions that have not yet been filled read as 0.
- R3: While unlocked, a valid bit that matches the prediction extends the run, and a mismatch resets the run to zero. `locked` goes to 1 on the clock edge that samples the 32nd consecutive matching valid bit, and it is visible in the following cycle.
- R4: While locked, the register shifts in its own prediction and ignores `rx_bit`. Each valid bit that differs from the prediction raises `err_count` by exactly one. An isolated flipped bit in an otherwise correct stream therefore adds exactly 1.
- R5: While unlocked, `err_count` does not change, except when cleared.
- R6: `err_count` saturates at 2^CNT_W - 1 and never wraps.
- R7: `clr_count` high at a clock edge makes `err_count` 0 after that edge. This takes priority over an increment at the same edge.
- R8: Lock divides the valid bits into consecutive windows of 64, the first window starting with the first valid bit after lock. The 17th error inside one window clears `locked` at that edge; that error is still counted. Relock then needs a new run of 32 matches, as in R3.
- R9: A cycle with `bit_valid` low changes neither the register, the run, the window state, `locked`, nor `err_count` (apart from R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | The value on `rx_bit` is a received bit this cycle |
| rx_bit | input | 1 | Received serial bit |
| clr_count | input | 1 | Clears the error counter |
| locked | output | 1 | Checker is locked and free-running |
| err_count | output | CNT_W | Saturating count of mismatches seen while locked |

## Verification
A fault in the predicting register shows at the ports in two ways. While hunting, it moves the cycle in which `locked` rises. While locked, it causes a steady stream of counted errors, and the window rule then drops lock within 64 valid bits. A wrong run or window counter shifts the rising or falling edge of `locked` by at least one valid bit. Because the bench compares `locked` and both counters after every clock, such a shift is caught in the cycle it happens. Bits with `bit_valid` low are interleaved with the stream, so any change during them is seen one cycle later.

// File: rtl/prbs_lock_checker.sv
module prbs_lock_checker #(
  parameter int W         = 15,
  parameter int TAP_A     = 15,
  parameter int TAP_B     = 14,
  parameter int LOCK_RUN  = 32,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 16,
  parameter int CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             rx_bit,
  input  logic             clr_count,
  output logic             locked,
  output logic [CNT_W-1:0] err_count
);
  localparam int RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int WIN_W  = $clog2(WIN + 1);
  localparam int WERR_W = $clog2(ERR_LIMIT + 2);

  logic [W-1:0]      lfsr;
  logic [RUN_W-1:0]  run_cnt;
  logic [WIN_W-1:0]  win_cnt;
  logic [WERR_W-1:0] win_err;

  wire              pred     = lfsr[TAP_A-1] ^ lfsr[TAP_B-1];
  wire              miss     = rx_bit ^ pred;
  wire              hit      = bit_valid & locked & miss;
  wire [WERR_W-1:0] win_err_nx = win_err + WERR_W'(hit);
  wire              drop     = hit && (win_err_nx > WERR_W'(ERR_LIMIT));
  wire              cnt_full = &err_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr    <= '0;
      run_cnt <= '0;
      win_cnt <= '0;
      win_err <= '0;
      locked  <= 1'b0;
    end else if (bit_valid) begin
      lfsr <= {lfsr[W-2:0], locked ? pred : rx_bit};
      if (!locked) begin
        if (miss) run_cnt <= '0;
        else if (run_cnt == RUN_W'(LOCK_RUN - 1)) begin
          locked  <= 1'b1;
          run_cnt <= '0;
          win_cnt <= '0;
          win_err <= '0;
        end else run_cnt <= run_cnt + 1'b1;
      end else if (drop) begin
        locked  <= 1'b0;
        run_cnt <= '0;
      end else if (win_cnt == WIN_W'(WIN - 1)) begin
        win_cnt <= '0;
        win_err <= '0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
        win_err <= win_err_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                err_count <= '0;
    else if (clr_count)        err_count <= '0;
    else if (hit && !cnt_full) err_count <= err_count + 1'b1;
  end

  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_count |=> (err_count == '0));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_count |=> (err_count >= $past(err_count)));

  a_r4_step_of_one: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_count |=> (err_count - $past(err_count) <= CNT_W'(1)));

  a_r5_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !clr_count) |=> $stable(err_count));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !clr_count) |=> ($stable(err_count) && $stable(locked)));

  a_r3_lock_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !bit_valid) |=> !locked);

  a_r8_drop_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(bit_valid && miss)) |=> locked);
endmodule

// File: tb/test_prbs_lock_checker.sv
`timescale 1ns/1ps
module test_prbs_lock_checker;
  logic clk = 1'b0, rst_n = 1'b0, bit_valid = 1'b0, rx_bit = 1'b0, clr_count = 1'b0;
  logic locked, locked_s;
  logic [31:0] err_count;
  logic [3:0]  err_sat;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prbs_lock_checker i_prbs_lock_checker (.clk(clk), .rst_n(rst_n), .bit_valid(bit_valid),
    .rx_bit(rx_bit), .clr_count(clr_count), .locked(locked), .err_count(err_count));
  prbs_lock_checker #(.CNT_W(4)) i_prbs_lock_checker_sat (.clk(clk), .rst_n(rst_n),
    .bit_valid(bit_valid), .rx_bit(rx_bit), .clr_count(clr_count), .locked(locked_s),
    .err_count(err_sat));

  // requirement model
  logic [14:0] m_s = '0, gen = 15'h0001;
  int m_run = 0, m_win = 0, m_werr = 0;
  bit m_lock = 0;
  longint m_err = 0;
  int m_sat = 0;

  task automatic check(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit next_gen();
    bit t = gen[14] ^ gen[13];
    gen = {gen[13:0], t};
    return t;
  endfunction

  task automatic step(bit v, bit b, bit c);
    bit p, e, dropped;
    bit_valid = v; rx_bit = b; clr_count = c;
    @(posedge clk);
    if (v) begin
      p = m_s[14] ^ m_s[13];
      if (!m_lock) begin
        m_s = {m_s[13:0], b};
        if (b != p) m_run = 0;
        else if (m_run == 31) begin m_lock = 1; m_run = 0; m_win = 0; m_werr = 0; end
        else m_run++;
      end else begin
        m_s = {m_s[13:0], p};
        e = (b != p);
        dropped = 0;
        if (e) begin
          m_err++;
          if (m_sat < 15) m_sat++;
          if (m_werr + 1 > 16) begin m_lock = 0; m_run = 0; dropped = 1; end
        end
        if (!dropped) begin
          if (m_win == 63) begin m_win = 0; m_werr = 0; end
          else begin m_win++; m_werr += e; end
        end
      end
    end
    if (c) begin m_err = 0; m_sat = 0; end
    @(negedge clk);
    check("R2 R3 R8 lock", locked, m_lock);
    check("R4 R5 R7 count", err_count, m_err);
    check("R6 saturating count", err_sat, m_sat);
  endtask

  task automatic send(int n, bit err_at_end);
    for (int i = 0; i < n; i++) begin
      bit t = next_gen();
      step(1'b1, t ^ (err_at_end && i == n - 1), 1'b0);
    end
  endtask

  initial begin
    longint base;
    repeat (3) @(negedge clk);
    check("R1 locked", locked, 0);
    check("R1 count", err_count, 0);
    rst_n = 1'b1;
    // R5: garbage before lock never counts
    for (int i = 0; i < 40; i++) step(1'b1, 1'(i % 3 == 0), 1'b0);
    check("R5 no count unlocked", err_count, 0);
    // R2, R3: clean stream locks
    send(100, 0);
    check("R3 locked after clean run", locked, 1);
    // R9: gaps with toggling data
    for (int i = 0; i < 60; i++) begin
      if (i % 2) step(1'b0, 1'(i % 4 == 1), 1'b0);
      else send(1, 0);
    end
    check("R9 gaps keep lock", locked, 1);
    check("R9 gaps no errors", err_count, 0);
    // R4: isolated errors each count once
    base = err_count;
    for (int k = 0; k < 10; k++) send(20, 1);
    check("R4 ten single errors", err_count - base, 10);
    // R7: clear at same edge as an error
    begin
      bit t = next_gen();
      step(1'b1, ~t, 1'b1);
    end
    check("R7 clear wins", err_count, 0);
    // R8: long burst drops lock, relock later
    for (int i = 0; i < 40; i++) begin
      bit t = next_gen();
      step(1'b1, ~t, 1'b0);
    end
    check("R8 burst drops lock", locked, 0);
    send(100, 0);
    check("R8 relock", locked, 1);
    // R6: saturation in narrow instance
    for (int k = 0; k < 20; k++) send(8, 1);
    check("R6 saturated", err_sat, 15);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 4) != 0;
      bit t = v ? next_gen() : 1'b0;
      bit f = ($urandom % 40) == 0;
      bit c = ($urandom % 500) == 0;
      step(v, t ^ f, c);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule